// File: doc/BRIEF.md
# Dual Timer/Counter with External Gating

This block holds two 16-bit timer/counter units behind a small byte-wide register port. Each unit advances either on the internal machine-cycle tick or on falling edges of its own external count pin. A run bit switches the unit on. An optional gate makes the unit also wait for its gate pin to be high, which lets an external signal measure pulse widths. On rollover a unit raises a sticky overflow flag. The flag is dropped by a one-cycle acknowledge strobe, which the interrupt controller drives when it vectors to the matching handler.

Each unit has four width modes:
- a 13-bit count, built from a 5-bit prescaler under an 8-bit high byte;
- a plain 16-bit count;
- an 8-bit count that reloads from the high byte;
- a split mode. In split mode unit 0 becomes two independent 8-bit counters. Unit 1 in split mode freezes.

Writes, the tick, pins and acknowledges are sampled on the rising clock edge. Reads are combinational. All pins are assumed to be synchronous to the clock.

Top module: `dual_timer_counter`

## Requirements
- R1: After reset every readable register reads 0x00 and both overflow flag outputs are low.
- R2: Register map: address 0 is control, with bit7 = flag1, bit6 = run1, bit5 = flag0, bit4 = run0, and bits 3:0 reading 0. Address 1 is mode, with unit 1 in bits 7:4 and unit 0 in bits 3:0. Within each nibble: bit3 = gate enable, bit2 = external-count select, bits 1:0 = width mode. Addresses 2/3 are unit 0 low/high count, 4/5 are unit 1 low/high count, and 6/7 read 0. A write takes effect at the clock edge where it is sampled.
- R3: A unit advances by one only in a cycle where tick is high and its effective run is true. With the run bit at 0, or with tick low, the count holds.
- R4: With the gate enable at 1, effective run requires the run bit and a high gate pin. With the gate enable at 0, the run bit alone decides.
- R5: With external-count select at 1, a unit advances on a tick where its count pin is low and the pin was high at the previous tick. The pin is sampled only on ticks, and the sampled value resets to 0.
- R6: Width mode 01 is a 16-bit count. Going from 0xFFFF to 0x0000 sets the unit's flag at that edge.
- R7: Width mode 00 is a 13-bit count. The prescaler is the low 5 bits of the low byte, and bits 7:5 of the low byte are untouched. Overflow occurs when the high byte is 0xFF and the prescaler is 0x1F.
- R8: Width mode 10 advances the low byte only. When the low byte is 0xFF, it is loaded with the high byte instead and the flag is set.
- R9: When unit 0 has width mode 11:
  - its low byte is an 8-bit counter under unit 0's controls and sets flag0 when it wraps;
  - its high byte counts ticks under run1 alone (no gate, no external pin) and sets flag1 when it wraps;
  - overflows of unit 1 then do not set flag1.
  
  Unit 1 in width mode 11 holds its count.
- R10: A flag stays set until cleared. An overflow in the same cycle as the acknowledge leaves the flag set. An acknowledge alone clears it. A control write loads the flag bit only when there is neither an overflow nor an acknowledge for that flag.
- R11: A write to a count byte in the same cycle as an advance wins. In modes 00, 01 and 10, a write to either byte of a unit cancels that cycle's advance and its overflow. In split mode each byte is cancelled only by a write to itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Machine-cycle strobe, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| cnt_pin | input | 2 | External count inputs, bit n for unit n |
| gate_pin | input | 2 | Gate inputs, bit n for unit n |
| ovf_ack | input | 2 | Flag acknowledge strobes, bit n clears flag n |
| ovf_flag | output | 2 | Sticky overflow flags |

## Verification
Two pairs of functions can land in the same cycle:
- an overflow that sets a flag and the acknowledge or control write that clears or loads it;
- a software write to a count byte and the tick that would advance that byte.

The bench provokes both on purpose with directed sequences that aim the write or acknowledge at the wrapping tick. It also provokes them at random, by loading count bytes with 0xFF or 0xFE while ticks, acknowledges and writes are drawn at random. A reference model built from the priority rules in R10 and R11 judges every register and both flags after each cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_UNITS = 2;
  localparam int RUN_BIT0  = 4;   // run bit of unit n sits at RUN_BIT0 + 2n
  localparam int FLAG_BIT0 = 5;   // flag bit of unit n sits at FLAG_BIT0 + 2n

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_MODE = 3'd1;
  localparam logic [2:0] A_T0L  = 3'd2;
  localparam logic [2:0] A_T0H  = 3'd3;
  localparam logic [2:0] A_T1L  = 3'd4;
  localparam logic [2:0] A_T1H  = 3'd5;

  typedef enum logic [1:0] {
    MD_13     = 2'b00,
    MD_16     = 2'b01,
    MD_RELOAD = 2'b10,
    MD_SPLIT  = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext;
    tmr_mode_e mode;
  } unit_cfg_t;
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic fall
);
  logic prev_q, prev_d;

  always_comb prev_d = tick ? pin : prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign fall = tick & prev_q & ~pin;

  // R5: a detected fall leaves a low sample behind
  a_r5_fall_leaves_low: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !prev_q);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter bit HAS_SPLIT = 1'b0,
  parameter int BYTE_W    = 8,
  parameter int PRE_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run_bit,
  input  logic              gate_pin,
  input  logic              fall,
  input  logic              split_run,
  input  unit_cfg_t         cfg,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic              ovf_main,
  output logic              ovf_split
);
  localparam int WIDE_W  = 2 * BYTE_W;
  localparam int SHORT_W = BYTE_W + PRE_W;

  logic [BYTE_W-1:0]  lo_q, hi_q, lo_d, hi_d;
  logic [WIDE_W-1:0]  wide_nx;
  logic [SHORT_W-1:0] short_nx;
  logic               run_eff, adv, hi_adv, wr_any;

  assign run_eff = run_bit & (~cfg.gate | gate_pin);
  assign adv     = tick & run_eff & (~cfg.ext | fall);
  assign hi_adv  = tick & split_run & HAS_SPLIT;
  assign wr_any  = wr_lo | wr_hi;

  always_comb begin
    lo_d      = lo_q;
    hi_d      = hi_q;
    ovf_main  = 1'b0;
    ovf_split = 1'b0;
    wide_nx   = {hi_q, lo_q} + 1'b1;
    short_nx  = {hi_q, lo_q[PRE_W-1:0]} + 1'b1;
    case (cfg.mode)
      MD_13: if (adv && !wr_any) begin
        hi_d              = short_nx[SHORT_W-1:PRE_W];
        lo_d[PRE_W-1:0]   = short_nx[PRE_W-1:0];
        ovf_main          = &{hi_q, lo_q[PRE_W-1:0]};
      end
      MD_16: if (adv && !wr_any) begin
        {hi_d, lo_d} = wide_nx;
        ovf_main     = &{hi_q, lo_q};
      end
      MD_RELOAD: if (adv && !wr_any) begin
        ovf_main = &lo_q;
        lo_d     = (&lo_q) ? hi_q : lo_q + 1'b1;
      end
      MD_SPLIT: if (HAS_SPLIT) begin
        if (adv && !wr_lo) begin
          lo_d     = lo_q + 1'b1;
          ovf_main = &lo_q;
        end
        if (hi_adv && !wr_hi) begin
          hi_d      = hi_q + 1'b1;
          ovf_split = &hi_q;
        end
      end
      default: ;
    endcase
    if (wr_lo) lo_d = wr_data;
    if (wr_hi) hi_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign cnt_lo = lo_q;
  assign cnt_hi = hi_q;

  // R3: no tick and no write means the count stays put
  a_r3_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !wr_any |=> $stable({hi_q, lo_q}));
  // R11: a low-byte write always lands
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> lo_q == $past(wr_data));
  // R8: reload copies the high byte into the low byte
  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.mode == MD_RELOAD && ovf_main |=> lo_q == $past(hi_q));
  // R6: a 16-bit overflow leaves zero behind
  a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.mode == MD_16 && ovf_main |=> {hi_q, lo_q} == '0);
  // R9: a unit without split support freezes in mode 11
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_SPLIT && cfg.mode == MD_SPLIT && !wr_any |=> $stable({hi_q, lo_q}));
endmodule

// File: rtl/dual_timer_counter.sv
module dual_timer_counter
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [1:0]        cnt_pin,
  input  logic [1:0]        gate_pin,
  input  logic [1:0]        ovf_ack,
  output logic [1:0]        ovf_flag
);
  localparam int CFG_W = $bits(unit_cfg_t);
  localparam int MODE_W = CFG_W * NUM_UNITS;

  logic [NUM_UNITS-1:0] run_q, run_d, flag_q, flag_d, set_evt;
  logic [NUM_UNITS-1:0] fall, ovf_main, ovf_split, wr_lo, wr_hi;
  logic [MODE_W-1:0]    mode_q, mode_d;
  logic [BYTE_W-1:0]    cnt_lo [NUM_UNITS];
  logic [BYTE_W-1:0]    cnt_hi [NUM_UNITS];
  unit_cfg_t            cfg [NUM_UNITS];
  logic                 ctrl_wr, mode_wr, split0;

  assign ctrl_wr = wr_en && wr_addr == A_CTRL;
  assign mode_wr = wr_en && wr_addr == A_MODE;
  assign wr_lo   = {wr_en && wr_addr == A_T1L, wr_en && wr_addr == A_T0L};
  assign wr_hi   = {wr_en && wr_addr == A_T1H, wr_en && wr_addr == A_T0H};

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign cfg[u] = unit_cfg_t'(mode_q[CFG_W*u +: CFG_W]);

    tmr_edge u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .pin  (cnt_pin[u]),
      .fall (fall[u])
    );

    tmr_unit #(
      .HAS_SPLIT(u == 0),
      .BYTE_W   (BYTE_W),
      .PRE_W    (PRE_W)
    ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .run_bit  (run_q[u]),
      .gate_pin (gate_pin[u]),
      .fall     (fall[u]),
      .split_run(u == 0 ? run_q[NUM_UNITS-1] : 1'b0),
      .cfg      (cfg[u]),
      .wr_lo    (wr_lo[u]),
      .wr_hi    (wr_hi[u]),
      .wr_data  (wr_data),
      .cnt_lo   (cnt_lo[u]),
      .cnt_hi   (cnt_hi[u]),
      .ovf_main (ovf_main[u]),
      .ovf_split(ovf_split[u])
    );

    // R10: an overflow sets the flag even against an acknowledge
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[u] |=> ovf_flag[u]);
    // R10: an acknowledge without an overflow clears the flag
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_ack[u] && !set_evt[u] |=> !ovf_flag[u]);
  end

  assign split0     = cfg[0].mode == MD_SPLIT;
  assign set_evt[0] = ovf_main[0];
  assign set_evt[1] = split0 ? ovf_split[0] : (ovf_main[1] | ovf_split[1]);

  always_comb begin
    mode_d = mode_wr ? wr_data[MODE_W-1:0] : mode_q;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (set_evt[i])      flag_d[i] = 1'b1;
      else if (ovf_ack[i]) flag_d[i] = 1'b0;
      else if (ctrl_wr)    flag_d[i] = wr_data[FLAG_BIT0 + 2*i];
      else                 flag_d[i] = flag_q[i];
      run_d[i] = ctrl_wr ? wr_data[RUN_BIT0 + 2*i] : run_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      flag_q <= '0;
      mode_q <= '0;
    end else begin
      run_q  <= run_d;
      flag_q <= flag_d;
      mode_q <= mode_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: rd_data[7:4] = {flag_q[1], run_q[1], flag_q[0], run_q[0]};
      A_MODE: rd_data[MODE_W-1:0] = mode_q;
      A_T0L:  rd_data = cnt_lo[0];
      A_T0H:  rd_data = cnt_hi[0];
      A_T1L:  rd_data = cnt_lo[1];
      A_T1H:  rd_data = cnt_hi[1];
      default: rd_data = '0;
    endcase
  end

  assign ovf_flag = flag_q;

  // R9: while unit 0 is split, a unit 1 wrap alone does not raise flag1
  a_r9_split_masks_t1: assert property (@(posedge clk) disable iff (!rst_n)
    split0 && ovf_main[1] && !ovf_split[0] && !flag_q[1] && !ctrl_wr |=> !ovf_flag[1]);
endmodule

// File: tb/tb_dual_timer_counter.sv
`timescale 1ns/1ps
module tb_dual_timer_counter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick, wr_en;
  logic [2:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [1:0] cnt_pin, gate_pin, ovf_ack, ovf_flag;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] m_lo [2];
  logic [7:0] m_hi [2];
  logic [7:0] m_mode;
  logic [1:0] m_run, m_flag, m_prev;
  logic [1:0] cp_v, gp_v;

  always #2.5 clk = ~clk;

  dual_timer_counter dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .ovf_ack(ovf_ack), .ovf_flag(ovf_flag)
  );

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {m_flag[1], m_run[1], m_flag[0], m_run[0], 4'h0};
      3'd1: return m_mode;
      3'd2: return m_lo[0];
      3'd3: return m_hi[0];
      3'd4: return m_lo[1];
      3'd5: return m_hi[1];
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_step(input logic tk, input logic [1:0] cp, input logic [1:0] gp,
                            input logic we, input logic [2:0] wa, input logic [7:0] wd,
                            input logic [1:0] ak);
    logic [7:0] nlo [2];
    logic [7:0] nhi [2];
    logic [1:0] ov, ovs, setv;
    for (int u = 0; u < 2; u++) begin
      logic [1:0]  md;
      logic        gt, ex, wl, wh, adv, hadv;
      logic [12:0] v13;
      logic [15:0] v16;
      md   = m_mode[4*u +: 2];
      ex   = m_mode[4*u+2];
      gt   = m_mode[4*u+3];
      adv  = tk && m_run[u] && (!gt || gp[u]) && (!ex || (m_prev[u] && !cp[u]));
      wl   = we && wa == 3'(2 + 2*u);
      wh   = we && wa == 3'(3 + 2*u);
      hadv = (u == 0) && tk && m_run[1];
      nlo[u] = m_lo[u]; nhi[u] = m_hi[u]; ov[u] = 1'b0; ovs[u] = 1'b0;
      case (md)
        2'd0: if (adv && !wl && !wh) begin
          v13 = {m_hi[u], m_lo[u][4:0]};
          ov[u] = (v13 == 13'h1fff);
          v13 = v13 + 13'd1;
          nhi[u] = v13[12:5];
          nlo[u][4:0] = v13[4:0];
        end
        2'd1: if (adv && !wl && !wh) begin
          v16 = {m_hi[u], m_lo[u]};
          ov[u] = (v16 == 16'hffff);
          v16 = v16 + 16'd1;
          nhi[u] = v16[15:8];
          nlo[u] = v16[7:0];
        end
        2'd2: if (adv && !wl && !wh) begin
          if (m_lo[u] == 8'hff) begin nlo[u] = m_hi[u]; ov[u] = 1'b1; end
          else nlo[u] = m_lo[u] + 8'd1;
        end
        default: if (u == 0) begin
          if (adv && !wl) begin ov[u] = (m_lo[u] == 8'hff); nlo[u] = m_lo[u] + 8'd1; end
          if (hadv && !wh) begin ovs[u] = (m_hi[u] == 8'hff); nhi[u] = m_hi[u] + 8'd1; end
        end
      endcase
      if (wl) nlo[u] = wd;
      if (wh) nhi[u] = wd;
    end
    setv[0] = ov[0];
    setv[1] = (m_mode[1:0] == 2'b11) ? ovs[0] : ov[1];
    for (int i = 0; i < 2; i++) begin
      if (setv[i])                  m_flag[i] = 1'b1;
      else if (ak[i])               m_flag[i] = 1'b0;
      else if (we && wa == 3'd0)    m_flag[i] = wd[5 + 2*i];
    end
    if (we && wa == 3'd0) m_run = {wd[6], wd[4]};
    if (we && wa == 3'd1) m_mode = wd;
    if (tk) m_prev = cp;
    for (int u = 0; u < 2; u++) begin m_lo[u] = nlo[u]; m_hi[u] = nhi[u]; end
  endtask

  task automatic cycle(input logic tk, input logic we, input logic [2:0] wa,
                       input logic [7:0] wd, input logic [1:0] ak);
    tick = tk; wr_en = we; wr_addr = wa; wr_data = wd; ovf_ack = ak;
    cnt_pin = cp_v; gate_pin = gp_v;
    model_step(tk, cp_v, gp_v, we, wa, wd, ak);
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0; ovf_ack = 2'b00;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cycle(1'b0, 1'b1, a, d, 2'b00);
  endtask

  task automatic idle(input logic tk);
    cycle(tk, 1'b0, 3'd0, 8'h00, 2'b00);
  endtask

  task automatic chk(input string tag, input logic [2:0] a);
    rd_addr = a;
    #0.1;
    n_chk++;
    if (rd_data !== exp_rd(a)) begin
      n_bad++;
      $display("FAIL %s addr %0d: actual=%02h expected=%02h", tag, a, rd_data, exp_rd(a));
    end
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < 6; a++) chk(tag, 3'(a));
    n_chk++;
    if (ovf_flag !== m_flag) begin
      n_bad++;
      $display("FAIL %s flags: actual=%b expected=%b", tag, ovf_flag, m_flag);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; tick = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    ovf_ack = 0; cp_v = 2'b00; gp_v = 2'b11; cnt_pin = cp_v; gate_pin = gp_v;
    m_lo[0] = 0; m_lo[1] = 0; m_hi[0] = 0; m_hi[1] = 0;
    m_mode = 0; m_run = 0; m_flag = 0; m_prev = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2: map and readback
    wr(3'd1, 8'h11); wr(3'd2, 8'h34); wr(3'd3, 8'h12); wr(3'd4, 8'h78); wr(3'd5, 8'h56);
    wr(3'd0, 8'h0F);
    check_all("R2");

    // R3: run and tick
    wr(3'd0, 8'h10);
    idle(1'b0); idle(1'b0); check_all("R3");
    idle(1'b1); idle(1'b1); check_all("R3");
    wr(3'd0, 8'h00); idle(1'b1); check_all("R3");

    // R4: gating
    wr(3'd1, 8'h09); wr(3'd0, 8'h10);
    gp_v = 2'b10; idle(1'b1); idle(1'b1); check_all("R4");
    gp_v = 2'b11; idle(1'b1); check_all("R4");

    // R5: external edges
    wr(3'd1, 8'h05);
    cp_v = 2'b01; idle(1'b1);
    cp_v = 2'b00; idle(1'b1); check_all("R5");
    idle(1'b1); check_all("R5");
    cp_v = 2'b01; idle(1'b0);
    cp_v = 2'b00; idle(1'b0); check_all("R5");
    idle(1'b1); check_all("R5");

    // R6: 16-bit wrap
    wr(3'd1, 8'h01); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    idle(1'b1); check_all("R6");
    idle(1'b1); check_all("R6");
    cycle(1'b0, 1'b0, 3'd0, 8'h00, 2'b01);

    // R7: 13-bit wrap with untouched upper low-byte bits
    wr(3'd1, 8'h00); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    idle(1'b1); check_all("R7");
    idle(1'b1); check_all("R7");
    cycle(1'b0, 1'b0, 3'd0, 8'h00, 2'b01);

    // R8: reload
    wr(3'd1, 8'h02); wr(3'd2, 8'hFE); wr(3'd3, 8'h80);
    idle(1'b1); idle(1'b1); check_all("R8");
    idle(1'b1); check_all("R8");
    cycle(1'b0, 1'b0, 3'd0, 8'h00, 2'b01);

    // R9: split unit 0, frozen unit 1
    wr(3'd1, 8'h33); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd4, 8'h10);
    wr(3'd0, 8'h50);
    idle(1'b1); check_all("R9");
    cycle(1'b0, 1'b0, 3'd0, 8'h00, 2'b11);
    wr(3'd1, 8'h13); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); wr(3'd3, 8'h00);
    idle(1'b1); check_all("R9");

    // R10: flag priorities
    wr(3'd1, 8'h01); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd0, 8'h10);
    cycle(1'b1, 1'b0, 3'd0, 8'h00, 2'b01); check_all("R10");
    cycle(1'b0, 1'b0, 3'd0, 8'h00, 2'b01); check_all("R10");
    wr(3'd0, 8'hB0); check_all("R10");
    cycle(1'b0, 1'b1, 3'd0, 8'hA0, 2'b10); check_all("R10");

    // R11: write against increment on the wrapping tick
    cycle(1'b0, 1'b0, 3'd0, 8'h00, 2'b01);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd0, 8'h10);
    cycle(1'b1, 1'b1, 3'd2, 8'h00, 2'b00); check_all("R11");
    wr(3'd1, 8'h03); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd0, 8'h50);
    cycle(1'b1, 1'b1, 3'd3, 8'h42, 2'b00); check_all("R11");

    // random phase, all registers compared after each cycle (R2 readback)
    for (int k = 0; k < 3000; k++) begin
      logic       tk, we;
      logic [2:0] wa;
      logic [7:0] wd;
      logic [1:0] ak;
      tk = 1'($urandom % 2);
      we = ($urandom % 4) == 0;
      wa = 3'($urandom % 8);
      case ($urandom % 3)
        0: wd = 8'hFF;
        1: wd = 8'hFE;
        default: wd = 8'($urandom);
      endcase
      ak = {($urandom % 8) == 0, ($urandom % 8) == 0};
      if (($urandom % 3) == 0) cp_v = 2'($urandom);
      gp_v = {($urandom % 4) != 0, ($urandom % 4) != 0};
      cycle(tk, we, wa, wd, ak);
      check_all("R2");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule